// File: doc/BRIEF.md
# USB Bus Suspend and Resume Detector

This block watches the decoded state of a USB full-speed line and tracks when the link enters and leaves suspend. A counter runs while the line stays in the idle (J) state with no traffic. Once the idle time exceeds a configured number of clock cycles (3 ms at the system clock), the block sets its suspend status bit. Any traffic, or any line state other than J, restarts the count.

While the link is suspended, a K state from the host is resume signalling. The block sets a latched resume flag as soon as it sees the K state. When the K state ends, the suspend bit drops. The host's resume signalling finishes before the suspend bit clears, so firmware could otherwise miss it. For this reason the resume flag stays set until firmware clears it by writing 1.

Every link transition raises a one-cycle interrupt pulse and also sets a pending flag, which firmware clears. There are three such transitions: suspend entry, resume detection and suspend exit. The block also holds the firmware's USB clock-enable setting. Firmware clears it on suspend and sets it again on resume, and the block drives a gate request from it. All pins are plain level or pulse control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `usb_suspend_detect`

## Requirements
- R1: After reset, suspend, resume_flag, irq_pulse, irq_pending and usb_clk_gate are all 0, so the USB clock is enabled.
- R2: A cycle is idle when line_j=1, line_k=0 and bus_act=0. On the (IDLE_LIMIT+1)-th consecutive idle cycle, suspend rises on that clock edge, and irq_pulse is 1 in the same cycle.
- R3: A non-idle cycle restarts the idle count. After IDLE_LIMIT idle cycles, one non-idle cycle and then IDLE_LIMIT more idle cycles, suspend is still 0.
- R4: While suspend=1, a cycle with line_k=1 sets resume_flag, and irq_pulse is 1 in the following cycle. Holding K for more cycles raises no further pulse.
- R5: While resume signalling is in progress, the first cycle with line_k=0 clears suspend, and irq_pulse is 1 at that point.
- R6: resume_flag stays 1 after suspend clears. A cycle with fw_resume_clr=1 clears it. A new resume detection in the same cycle wins over the clear.
- R7: irq_pulse lasts one cycle per event. Each pulse sets irq_pending, which holds until a cycle with fw_pend_clr=1. A new event in the same cycle wins over the clear.
- R8: The clock-enable bit resets to 1. fw_clken_clr=1 clears it, and fw_clken_set=1 sets it, with set winning when both are 1. usb_clk_gate is the inverse of the bit.
- R9: While suspend=0, a K state is not resume signalling. It does not change resume_flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_j | input | 1 | Decoded line is in the J (idle) state |
| line_k | input | 1 | Decoded line is in the K state |
| bus_act | input | 1 | Packet traffic seen on the bus this cycle |
| fw_clken_set | input | 1 | Firmware sets the USB clock enable |
| fw_clken_clr | input | 1 | Firmware clears the USB clock enable |
| fw_resume_clr | input | 1 | Firmware writes 1 to clear the resume flag |
| fw_pend_clr | input | 1 | Firmware clears the interrupt pending flag |
| suspend | output | 1 | Suspend status bit |
| resume_flag | output | 1 | Latched resume status bit |
| irq_pulse | output | 1 | One-cycle interrupt on each link transition |
| irq_pending | output | 1 | Interrupt pending flag |
| usb_clk_gate | output | 1 | Request to gate the USB clock |

## Verification
An idle counter that drifts or fails to restart shows up at the suspend pin one cycle too early or too late. The idle-limit boundary checks catch this on the exact cycle it happens. A link state machine stuck in the wrong state shows up as a missing or extra irq_pulse on the cycle where K appears or disappears. Because the bench compares the pins against its model on every cycle, a wrong resume flag or pending flag is seen within one cycle of the event or clear that exposes it.

// File: rtl/usbsr_pkg.sv
package usbsr_pkg;
  typedef enum logic [1:0] {
    LS_ACTIVE   = 2'd0,
    LS_SUSP     = 2'd1,
    LS_RESUMING = 2'd2
  } link_st_t;
endpackage

// File: rtl/usbsr_idle_timer.sv
module usbsr_idle_timer #(
  parameter int unsigned LIMIT = 36000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic idle,
  output logic expire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt;

  assign expire = run && idle && (cnt == LIM_C);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || !idle)  cnt <= '0;
    else if (cnt != LIM_C)   cnt <= cnt + 1'b1;
  end

  assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (cnt == '0));
endmodule

// File: rtl/usbsr_link_fsm.sv
module usbsr_link_fsm
  import usbsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_k,
  input  logic expire,
  output logic active,
  output logic suspended,
  output logic link_event,
  output logic resume_seen
);
  link_st_t st, st_nxt;

  always_comb begin
    st_nxt      = st;
    link_event  = 1'b0;
    resume_seen = 1'b0;
    unique case (st)
      LS_ACTIVE: if (expire) begin
        st_nxt = LS_SUSP; link_event = 1'b1;
      end
      LS_SUSP: if (line_k) begin
        st_nxt = LS_RESUMING; link_event = 1'b1; resume_seen = 1'b1;
      end
      LS_RESUMING: if (!line_k) begin
        st_nxt = LS_ACTIVE; link_event = 1'b1;
      end
      default: st_nxt = LS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= LS_ACTIVE;
    else        st <= st_nxt;
  end

  assign active    = (st == LS_ACTIVE);
  assign suspended = (st != LS_ACTIVE);

  assert_enter_from_expire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_SUSP && $past(st) == LS_ACTIVE) |-> $past(expire));
endmodule

// File: rtl/usbsr_status_regs.sv
module usbsr_status_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic link_event,
  input  logic resume_seen,
  input  logic fw_clken_set,
  input  logic fw_clken_clr,
  input  logic fw_resume_clr,
  input  logic fw_pend_clr,
  output logic resume_flag,
  output logic irq_pulse,
  output logic irq_pending,
  output logic usb_clk_gate
);
  logic clk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resume_flag <= 1'b0;
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
      clk_en      <= 1'b1;
    end else begin
      irq_pulse <= link_event;
      if (resume_seen)        resume_flag <= 1'b1;
      else if (fw_resume_clr) resume_flag <= 1'b0;
      if (link_event)         irq_pending <= 1'b1;
      else if (fw_pend_clr)   irq_pending <= 1'b0;
      if (fw_clken_set)       clk_en <= 1'b1;
      else if (fw_clken_clr)  clk_en <= 1'b0;
    end
  end

  assign usb_clk_gate = ~clk_en;

  assert_pulse_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_pending);
  assert_gate_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_clk_gate) |-> $past(fw_clken_clr) && !$past(fw_clken_set));
endmodule

// File: rtl/usb_suspend_detect.sv
module usb_suspend_detect #(
  parameter int unsigned IDLE_LIMIT = 36000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_j,
  input  logic line_k,
  input  logic bus_act,
  input  logic fw_clken_set,
  input  logic fw_clken_clr,
  input  logic fw_resume_clr,
  input  logic fw_pend_clr,
  output logic suspend,
  output logic resume_flag,
  output logic irq_pulse,
  output logic irq_pending,
  output logic usb_clk_gate
);
  logic idle, expire, active, link_event, resume_seen;

  assign idle = line_j && !line_k && !bus_act;

  usbsr_idle_timer #(.LIMIT(IDLE_LIMIT)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(active), .idle(idle), .expire(expire)
  );

  usbsr_link_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .line_k(line_k), .expire(expire),
    .active(active), .suspended(suspend),
    .link_event(link_event), .resume_seen(resume_seen)
  );

  usbsr_status_regs regs_i (
    .clk(clk), .rst_n(rst_n), .link_event(link_event), .resume_seen(resume_seen),
    .fw_clken_set(fw_clken_set), .fw_clken_clr(fw_clken_clr),
    .fw_resume_clr(fw_resume_clr), .fw_pend_clr(fw_pend_clr),
    .resume_flag(resume_flag), .irq_pulse(irq_pulse),
    .irq_pending(irq_pending), .usb_clk_gate(usb_clk_gate)
  );

  assert_suspend_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend) |-> irq_pulse);
  assert_resume_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_flag) |-> irq_pulse && suspend);
  assert_wake_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspend) |-> irq_pulse);
  assert_k_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && line_k) |=> !irq_pulse);
endmodule

// File: tb/usb_suspend_detect_tb.sv
`timescale 1ns/1ps
module usb_suspend_detect_tb_top;
  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_j = 1'b1, line_k = 1'b0, bus_act = 1'b0;
  logic clken_set = 1'b0, clken_clr = 1'b0, res_clr = 1'b0, pend_clr = 1'b0;
  logic suspend, resume_flag, irq_pulse, irq_pending, usb_clk_gate;

  int nchk = 0, nerr = 0;

  // reference model state
  int  m_st = 0;  // 0 active, 1 suspended, 2 resuming
  int  m_cnt = 0;
  bit  m_res = 0, m_irq = 0, m_pend = 0, m_en = 1;

  always #4 clk = ~clk;

  usb_suspend_detect #(.IDLE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_j(line_j), .line_k(line_k), .bus_act(bus_act),
    .fw_clken_set(clken_set), .fw_clken_clr(clken_clr),
    .fw_resume_clr(res_clr), .fw_pend_clr(pend_clr),
    .suspend(suspend), .resume_flag(resume_flag), .irq_pulse(irq_pulse),
    .irq_pending(irq_pending), .usb_clk_gate(usb_clk_gate)
  );

  task automatic check(string req, string what, logic act, bit exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit is_idle(bit j, bit k, bit a);
    return j && !k && !a;
  endfunction

  task automatic model_update();
    bit ev = 0, setres = 0;
    case (m_st)
      0: begin
        if (is_idle(line_j, line_k, bus_act)) begin
          if (m_cnt == LIM) begin ev = 1; m_st = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
      1: if (line_k) begin ev = 1; setres = 1; m_st = 2; end
      default: if (!line_k) begin ev = 1; m_st = 0; m_cnt = 0; end
    endcase
    m_irq = ev;
    if (setres) m_res = 1; else if (res_clr) m_res = 0;
    if (ev) m_pend = 1; else if (pend_clr) m_pend = 0;
    if (clken_set) m_en = 1; else if (clken_clr) m_en = 0;
  endtask

  // one cycle: inputs already driven at negedge; model at posedge; compare at next negedge
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check("R2", "suspend", suspend, m_st != 0);
    check("R4", "resume_flag", resume_flag, m_res);
    check("R7", "irq_pulse", irq_pulse, m_irq);
    check("R7", "irq_pending", irq_pending, m_pend);
    check("R8", "usb_clk_gate", usb_clk_gate, !m_en);
  endtask

  task automatic drive(bit j, bit k, bit a);
    line_j = j; line_k = k; bus_act = a;
    clken_set = 0; clken_clr = 0; res_clr = 0; pend_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "suspend", suspend, 0);
    check("R1", "resume_flag", resume_flag, 0);
    check("R1", "irq_pulse", irq_pulse, 0);
    check("R1", "irq_pending", irq_pending, 0);
    check("R1", "usb_clk_gate", usb_clk_gate, 0);

    // R3: LIM idle, one active cycle, LIM idle again -> still awake
    drive(1, 0, 0); repeat (LIM) step();
    drive(1, 0, 1); step();
    drive(1, 0, 0); repeat (LIM) step();
    check("R3", "suspend after restart", suspend, 0);
    // R2: one more idle cycle enters suspend with interrupt
    step();
    check("R2", "suspend at limit+1", suspend, 1);
    check("R2", "irq on entry", irq_pulse, 1);
    // R8 firmware gates the clock
    clken_clr = 1; step();
    check("R8", "gate after clear", usb_clk_gate, 1);
    drive(1, 0, 0); pend_clr = 1; step();
    check("R7", "pending cleared", irq_pending, 0);
    // R4 resume K
    drive(0, 1, 0); step();
    check("R4", "resume flag set", resume_flag, 1);
    check("R4", "irq on resume", irq_pulse, 1);
    step(); step();
    check("R4", "no repeat irq", irq_pulse, 0);
    check("R5", "still suspended during K", suspend, 1);
    // R8 both set and clear: set wins
    clken_set = 1; clken_clr = 1; step();
    check("R8", "set wins", usb_clk_gate, 0);
    // R5 K ends
    drive(1, 0, 0); step();
    check("R5", "suspend cleared", suspend, 0);
    check("R5", "irq on exit", irq_pulse, 1);
    check("R6", "resume flag kept", resume_flag, 1);
    step();
    check("R7", "pulse one cycle", irq_pulse, 0);
    // R6 clear
    drive(1, 0, 0); res_clr = 1; step();
    check("R6", "resume cleared", resume_flag, 0);
    // R9 K while awake
    drive(0, 1, 0); repeat (4) step();
    check("R9", "resume unaffected", resume_flag, 0);
    check("R9", "no irq", irq_pulse, 0);
    check("R9", "awake", suspend, 0);
    // R7 pending set wins over clear; R6 set wins over clear
    drive(1, 0, 0); repeat (LIM + 1) step();
    drive(0, 1, 0); res_clr = 1; pend_clr = 1; step();
    check("R6", "set wins over clear", resume_flag, 1);
    check("R7", "event wins over clear", irq_pending, 1);
    drive(1, 0, 0); step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit k;
      bit a;
      k = line_k;
      if (m_st != 0) begin if ($urandom_range(0, 5) == 0) k = !k; end
      else if ($urandom_range(0, 60) == 0) k = !k;
      else if (k && $urandom_range(0, 3) == 0) k = 0;
      a = ($urandom_range(0, 45) == 0);
      drive(!k, k, a);
      res_clr   = ($urandom_range(0, 15) == 0);
      pend_clr  = ($urandom_range(0, 7) == 0);
      clken_set = ($urandom_range(0, 20) == 0);
      clken_clr = ($urandom_range(0, 20) == 0);
      step();
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule